// File: doc/BRIEF.md
# Two-stage sigma-delta decimator

This block turns a one-bit oversampled modulator stream into signed 16-bit words at one thirty-second of the input sample rate. Two linear-phase FIR stages run one after the other. The first stage is a low-pass filter with 128 taps. Its input is a single bit, so each tap only adds or subtracts its coefficient, and the stage computes only every sixteenth output. The second stage is an 83-tap half-band filter. It takes the first stage's results, skips its zero-valued taps, keeps every second result, rounds it and saturates it to the output width.

A sample is taken on each clock edge where the enable input is high. Every count below is in enabled samples, not clock cycles. Both stages spread their multiply-accumulate work over the enabled samples between two of their own outputs. The coefficients are fixed when the block is elaborated, and they come from closed formulas.

Top module: `sd_decimator`

## Requirements
- R1: `out_valid` is high for exactly one clock cycle, in the cycle after each enabled sample whose count since reset (counting from 1) is a multiple of 32, once R6 allows output. It is low in every other cycle.
- R2: A clock edge with `mod_en` low takes no sample and advances no count. A run of disabled cycles produces no `out_valid` pulse and delays later words by the same number of cycles.
- R3: First-stage result k is the sum over i = 0..127 of c1(i)·s(n), where n = 16k − i is the sample index, s(n) = +1 for a sampled bit of 1 and −1 for a bit of 0, and c1(i) = min(i+1, 128−i).
- R4: The word emitted at sample 32F uses first-stage results x_j = result(2F−3−j), for j = 0..82. Its accumulator is 2048·x_41 plus the sum over odd d = 1..41 of h(d)·(x_{41−d} + x_{41+d}). Here h(d) is 1304 div d when d mod 4 = 1, and −(1304 div d) otherwise.
- R5: `out_data` is (acc + 256) arithmetically shifted right by 9, clamped to the range −32768 to 32767 and given in two's complement.
- R6: After reset, no word is emitted before enabled sample 1504 (frame 47). The first `out_valid` follows that sample, and at that point both delay lines hold only data taken since reset.
- R7: While reset is asserted, `out_valid` and `out_data` are 0, and all sample and frame counts restart. A reset in the middle of a run brings back the R6 fill delay.
- R8: `out_data` keeps its value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit | input | 1 | Modulator output bit (1 = positive) |
| mod_en | input | 1 | Sample qualifier; one bit is consumed per high cycle |
| out_data | output | 16 | Decimated signed result |
| out_valid | output | 1 | Single-cycle strobe marking a new result |

## Verification
The bench uses the default parameters: 128 taps and a factor of 16 in the first stage, and 83 taps in the half-band stage with a shift of 9. With these values the fill boundary at sample 1504 and several refills can be reached within a few thousand cycles. A constant stream of ones, or of zeros, pushes the rounded value past the upper or the lower limit, so both clamp branches are exercised, while random and alternating streams stay inside the range. Periodic enable drop-outs and one long idle stretch test the rule that counts advance only on enabled samples. A reset in the middle of a run tests the restart.

// File: rtl/sd_dec_pkg.sv
package sd_dec_pkg;

   // Triangular low-pass weight for tap i of an n-tap first stage
   function automatic int tri_tap(int i, int n);
      return (i + 1 < n - i) ? i + 1 : n - i;
   endfunction

   // Sum of all first-stage weights (bound on a stage-one result)
   function automatic int tri_sum(int n);
      int s;
      s = 0;
      for (int i = 0; i < n; i++) s += tri_tap(i, n);
      return s;
   endfunction

   // Half-band weight at odd offset d from the centre
   function automatic int hb_tap(int d, int k);
      return ((d % 4) == 1) ? (k / d) : -(k / d);
   endfunction

endpackage

// File: rtl/sd_fir1.sv
module sd_fir1 import sd_dec_pkg::*; #(
   parameter int N1   = 128,
   parameter int DEC  = 16,
   parameter int W1   = 16,
   parameter int S1_W = 4
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic                 bit_in,
   input  logic [S1_W-1:0]      step,
   output logic                 push,
   output logic signed [W1-1:0] y1
);
   localparam int TPS  = N1 / DEC;
   localparam int SUM1 = tri_sum(N1);

   typedef logic signed [W1-1:0] y_t;

   if (N1 % DEC != 0) begin : g_bad_ratio
      $error("sd_fir1: tap count must be a multiple of the decimation");
   end
   if (SUM1 >= (1 << (W1 - 1))) begin : g_bad_width
      $error("sd_fir1: result width too small for the weight sum");
   end

   logic [N1-1:0] sr, snap;
   y_t            acc, part;
   y_t            grp [DEC];

   // one group of TPS taps per accumulation step, weights are constants
   for (genvar g = 0; g < DEC; g++) begin : g_grp
      y_t gsum;
      always_comb begin
         gsum = '0;
         for (int t = 0; t < TPS; t++) begin
            if (snap[g*TPS + t]) gsum = gsum + W1'(tri_tap(g*TPS + t, N1));
            else                 gsum = gsum - W1'(tri_tap(g*TPS + t, N1));
         end
      end
      assign grp[g] = gsum;
   end

   always_comb begin
      part = '0;
      for (int g = 0; g < DEC; g++)
         if (step == S1_W'(g)) part = grp[g];
   end

   assign push = en && (step == S1_W'(DEC - 1));
   assign y1   = acc + part;

   always_ff @(posedge clk) begin
      if (rst) begin
         sr   <= '0;
         snap <= '0;
         acc  <= '0;
      end else if (en) begin
         sr <= {sr[N1-2:0], bit_in};
         if (step == S1_W'(DEC - 1)) begin
            snap <= {sr[N1-2:0], bit_in};
            acc  <= '0;
         end else begin
            acc <= acc + part;
         end
      end
   end

   // R3: a finished stage-one result never exceeds the weight sum
   p_y1_bound_r3: assert property (@(posedge clk) disable iff (rst)
      push |-> (y1 <= y_t'(SUM1)) && (y1 >= -y_t'(SUM1)));

endmodule

// File: rtl/sd_hb2.sv
module sd_hb2 import sd_dec_pkg::*; #(
   parameter int N2    = 83,
   parameter int DEC   = 16,
   parameter int W1    = 16,
   parameter int ACC_W = 32,
   parameter int OUT_W = 16,
   parameter int SHIFT = 9,
   parameter int HB_C  = 2048,
   parameter int HB_K  = 1304,
   parameter int CNT_W = 5
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic [CNT_W-1:0]     cnt,
   input  logic                 push,
   input  logic signed [W1-1:0] y1,
   input  logic                 emit,
   output logic [OUT_W-1:0]     out_data,
   output logic                 out_valid
);
   localparam int NPAIR = (N2 + 1) / 4;
   localparam int CTR   = (N2 - 1) / 2;
   localparam int NTERM = NPAIR + 1;
   localparam int NSTEP = (NTERM + 1) / 2;

   typedef logic signed [ACC_W-1:0] acc_t;
   typedef logic signed [W1-1:0]    y_t;

   localparam acc_t OMAX = acc_t'((1 << (OUT_W - 1)) - 1);
   localparam acc_t OMIN = acc_t'(-(1 << (OUT_W - 1)));

   if (N2 % 4 != 3) begin : g_bad_len
      $error("sd_hb2: half-band length must be 4k+3");
   end
   if (NSTEP > DEC - 1) begin : g_bad_steps
      $error("sd_hb2: accumulation does not fit between line shifts");
   end

   y_t   xl  [N2];
   acc_t grp [NSTEP];
   acc_t part, acc, rnd, sat;

   // two nonzero terms (or the centre) per step
   for (genvar s = 0; s < NSTEP; s++) begin : g_step
      acc_t gsum;
      always_comb begin
         int d;
         gsum = '0;
         for (int u = 0; u < 2; u++) begin
            d = 4*s + 2*u + 1;
            if (d > CTR) d = 0;
            if (2*s + u < NPAIR)
               gsum = gsum + acc_t'(hb_tap(d, HB_K)) *
                      (acc_t'(xl[CTR-d]) + acc_t'(xl[CTR+d]));
            else if (2*s + u == NPAIR)
               gsum = gsum + acc_t'(HB_C) * acc_t'(xl[CTR]);
         end
      end
      assign grp[s] = gsum;
   end

   always_comb begin
      part = '0;
      for (int s = 0; s < NSTEP; s++)
         if (cnt == CNT_W'(s)) part = grp[s];
   end

   always_comb begin
      rnd = (acc + (acc_t'(1) <<< (SHIFT - 1))) >>> SHIFT;
      if      (rnd > OMAX) sat = OMAX;
      else if (rnd < OMIN) sat = OMIN;
      else                 sat = rnd;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < N2; i++) xl[i] <= '0;
         acc       <= '0;
         out_data  <= '0;
         out_valid <= 1'b0;
      end else begin
         if (push) begin
            xl[0] <= y1;
            for (int i = 1; i < N2; i++) xl[i] <= xl[i-1];
         end
         if (en) begin
            if (cnt == '0) acc <= part;
            else           acc <= acc + part;
         end
         out_valid <= emit;
         if (emit) out_data <= sat[OUT_W-1:0];
      end
   end

   // R4: the line only shifts at the two stage-one completion phases
   p_push_phase_r4: assert property (@(posedge clk) disable iff (rst)
      push |-> (cnt == CNT_W'(DEC - 1)) || (cnt == CNT_W'(2*DEC - 1)));

endmodule

// File: rtl/sd_decimator.sv
module sd_decimator import sd_dec_pkg::*; #(
   parameter int N1    = 128,
   parameter int DEC1  = 16,
   parameter int N2    = 83,
   parameter int W1    = 16,
   parameter int ACC_W = 32,
   parameter int OUT_W = 16,
   parameter int SHIFT = 9,
   parameter int HB_C  = 2048,
   parameter int HB_K  = 1304
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             mod_bit,
   input  logic             mod_en,
   output logic [OUT_W-1:0] out_data,
   output logic             out_valid
);
   localparam int FRAME = 2 * DEC1;
   localparam int S1_W  = $clog2(DEC1);
   localparam int CNT_W = S1_W + 1;
   localparam int K0    = N1 / DEC1;
   localparam int FILL  = (K0 + N2 + 1) / 2 + 1;
   localparam int FW    = $clog2(FILL + 1);

   if ((1 << S1_W) != DEC1) begin : g_bad_dec
      $error("sd_decimator: first-stage decimation must be a power of two");
   end

   logic [CNT_W-1:0]     cnt;
   logic [FW-1:0]        frames;
   logic                 filled, frame_end, emit, push;
   logic signed [W1-1:0] y1;

   assign frame_end = mod_en && (cnt == CNT_W'(FRAME - 1));
   assign filled    = (frames >= FW'(FILL - 1));
   assign emit      = frame_end && filled;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         frames <= '0;
      end else if (mod_en) begin
         cnt <= cnt + 1'b1;
         if (frame_end && !filled) frames <= frames + 1'b1;
      end
   end

   sd_fir1 #(.N1(N1), .DEC(DEC1), .W1(W1), .S1_W(S1_W)) u_fir1 (
      .clk(clk), .rst(rst), .en(mod_en), .bit_in(mod_bit),
      .step(cnt[S1_W-1:0]), .push(push), .y1(y1)
   );

   sd_hb2 #(.N2(N2), .DEC(DEC1), .W1(W1), .ACC_W(ACC_W), .OUT_W(OUT_W),
            .SHIFT(SHIFT), .HB_C(HB_C), .HB_K(HB_K), .CNT_W(CNT_W)) u_hb2 (
      .clk(clk), .rst(rst), .en(mod_en), .cnt(cnt), .push(push), .y1(y1),
      .emit(emit), .out_data(out_data), .out_valid(out_valid)
   );

   // R1: the strobe never lasts two cycles
   p_valid_pulse_r1: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);
   // R2: a word only follows an enabled sample
   p_valid_after_sample_r2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(mod_en));
   // R8: the word holds between strobes
   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_data));

endmodule

// File: tb/tb_sd_decimator.sv
`timescale 1ns/1ps
module tb_sd_decimator;
   localparam int NT1 = 128, D1 = 16, NT2 = 83, CT = 41, NP = 21;
   localparam int FIRST_N = 1504;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mod_bit = 1'b0;
   logic        mod_en = 1'b0;
   logic [15:0] out_data;
   logic        out_valid;

   sd_decimator dut (.clk(clk), .rst(rst), .mod_bit(mod_bit), .mod_en(mod_en),
                     .out_data(out_data), .out_valid(out_valid));

   always #2 clk = ~clk;

   int   checks = 0, errors = 0;
   int   n = 0;
   bit   bits [0:16383];
   logic exp_v = 1'b0;
   int   exp_d = 0;
   bit   seen_first = 1'b0;
   int   gap_valids = 0;
   logic [15:0] lf = 16'hACE1;

   task automatic fail(input string tag, input int act, input int expv);
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
   endtask

   function automatic int w1(input int i);
      return (i + 1 < NT1 - i) ? i + 1 : NT1 - i;
   endfunction

   function automatic int wh(input int d);
      return ((d % 4) == 1) ? 1304 / d : -(1304 / d);
   endfunction

   function automatic longint y1f(input int k);
      longint s = 0;
      for (int i = 0; i < NT1; i++)
         s += bits[D1*k - i] ? w1(i) : -w1(i);
      return s;
   endfunction

   function automatic int model(input int nn);
      int m, base;
      longint acc, r;
      m    = nn / 32 - 1;
      base = 2*m - 1 - CT;
      acc  = 2048 * y1f(base);
      for (int p = 0; p < NP; p++)
         acc += wh(2*p + 1) * (y1f(base + 2*p + 1) + y1f(base - 2*p - 1));
      r = (acc + 256) >>> 9;
      if (r > 32767)  r = 32767;
      if (r < -32768) r = -32768;
      return int'(r);
   endfunction

   task automatic check_now();
      checks++;
      if (out_valid !== exp_v) fail("R1 strobe", int'(out_valid), int'(exp_v));
      checks++;
      if (int'($signed(out_data)) !== exp_d)
         fail(exp_v ? "R3 R4 R5 word" : "R8 hold", int'($signed(out_data)), exp_d);
      if (out_valid === 1'b1 && !seen_first) begin
         seen_first = 1'b1;
         checks++;
         if (n != FIRST_N) fail("R6 first word sample", n, FIRST_N);
      end
   endtask

   // one clock: check the previous edge, drive, predict the coming edge
   task automatic cyc(input logic b, input logic e, input logic r);
      @(negedge clk);
      check_now();
      rst = r; mod_bit = b; mod_en = e;
      if (r) begin
         n = 0; exp_v = 1'b0; exp_d = 0; seen_first = 1'b0;
      end else if (e) begin
         n++;
         bits[n] = b;
         if (n % 32 == 0 && n / 32 >= 47) begin
            exp_v = 1'b1;
            exp_d = model(n);
         end else begin
            exp_v = 1'b0;
         end
      end else begin
         exp_v = 1'b0;
      end
   endtask

   function automatic logic [15:0] lfsr_next(input logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   initial begin
      @(posedge clk);
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b1);
      cyc(1'b0, 1'b0, 1'b0);
      // R7: reset state
      checks++;
      if (out_valid !== 1'b0) fail("R7 reset strobe", int'(out_valid), 0);
      checks++;
      if (out_data !== 16'd0) fail("R7 reset word", int'(out_data), 0);

      // random bits with periodic enable drop-outs (R2, R3, R4)
      for (int i = 0; i < 1800; i++) begin
         lf = lfsr_next(lf);
         cyc(lf[0], (i % 7) != 3, 1'b0);
      end
      // R2: long idle stretch yields no word
      gap_valids = 0;
      for (int i = 0; i < 100; i++) begin
         cyc(1'b1, 1'b0, 1'b0);
         if (out_valid === 1'b1 && i > 0) gap_valids++;
      end
      checks++;
      if (gap_valids != 0) fail("R2 idle strobes", gap_valids, 0);

      // R5: constant ones clamp high
      for (int i = 0; i < 1700; i++) cyc(1'b1, 1'b1, 1'b0);
      checks++;
      if (int'($signed(out_data)) != 32767) fail("R5 upper clamp", int'($signed(out_data)), 32767);
      // R5: constant zeros clamp low
      for (int i = 0; i < 1700; i++) cyc(1'b0, 1'b1, 1'b0);
      checks++;
      if (int'($signed(out_data)) != -32768) fail("R5 lower clamp", int'($signed(out_data)), -32768);
      // alternating stream, mid-range values
      for (int i = 0; i < 1700; i++) cyc(i[0], 1'b1, 1'b0);
      for (int i = 0; i < 600; i++) begin
         lf = lfsr_next(lf);
         cyc(lf[3], 1'b1, 1'b0);
      end

      // R7: reset in mid-run restarts the fill count (R6 re-checked)
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1);
      cyc(1'b0, 1'b0, 1'b0);
      checks++;
      if (out_valid !== 1'b0 || out_data !== 16'd0)
         fail("R7 mid-run reset word", int'(out_data), 0);
      for (int i = 0; i < 1600; i++) begin
         lf = lfsr_next(lf);
         cyc(lf[5], 1'b1, 1'b0);
      end
      checks++;
      if (!seen_first) fail("R6 refill word seen", 0, 1);
      cyc(1'b0, 1'b0, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule